// File: doc/BRIEF.md
# Left Logical Shifter with Condition Flags

This block is the left logical shift step of a 32-bit processor datapath. It shifts one operand left by a count and fills the vacated low bits with zeros. It also builds the next value of the condition-code flags: the bit that left the word last goes to carry, overflow is forced low, and zero and negative follow the result. The top four flag bits are not touched by this operation, so they are carried through unchanged.

The shift count has three possible sources, chosen by a 2-bit select:

- a fixed count of one;
- a 6-bit immediate from the instruction;
- an 11-bit unsigned count that the decoder takes from the low bits of the upper half of a source register.

The fourth select code is reserved and shifts by zero. The shift and the flag logic are purely combinational. A single rank of output registers adds one clock of latency, so an operation can be issued on every cycle.

Top module: `lsl_flag_unit`

## Requirements
- R1: `cnt_src_i` picks the shift count N. Code 2'b00 gives N = 1, code 2'b01 gives N = `imm_cnt_i` as an unsigned value, code 2'b10 gives N = `cnt_reg_i` as an unsigned value, and code 2'b11 gives N = 0.
- R2: For 1 ≤ N ≤ 32, `res_o` equals `opnd_i` shifted left by N bits, with zeros filling the low N bits. When N = 32 the result is zero.
- R3: For 1 ≤ N ≤ 32, carry (`cc_out[0]`) equals bit 32−N of `opnd_i`, which is the last bit shifted out.
- R4: For N = 0, `res_o` equals `opnd_i` and carry is cleared.
- R5: For every N from 33 to 2047, `res_o` is zero and carry is cleared.
- R6: The overflow flag (`cc_out[1]`) is always cleared.
- R7: The zero flag (`cc_out[2]`) is set exactly when `res_o` is zero.
- R8: The negative flag (`cc_out[3]`) equals bit 31 of `res_o`.
- R9: `cc_out[7:4]` equals `cc_keep_i` unchanged. Operand and count have no effect on these bits.
- R10: All outputs are registered. A stimulus applied before a rising edge of `clk` appears on the outputs after that edge and not before it. While `rst_n` is low, `res_o` and `cc_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_i | input | 32 | Operand to shift |
| cnt_src_i | input | 2 | Count source select (see R1) |
| imm_cnt_i | input | 6 | Immediate shift count |
| cnt_reg_i | input | 11 | Register-supplied shift count |
| cc_keep_i | input | 4 | Incoming flag bits that pass through |
| res_o | output | 32 | Shifted result |
| cc_out | output | 8 | Flags: [0] carry, [1] overflow, [2] zero, [3] negative, [7:4] passed through |

## Verification
Every result and flag is due exactly one rising clock edge after its inputs are presented, and none of them changes any earlier than that. The bench drives inputs on a falling edge and compares the outputs on the next falling edge, after exactly one rising edge has passed. A separate check samples the outputs shortly after a new drive, before the rising edge, and confirms they still hold the previous result. Expected values come from a wide-integer model written from the requirements. The bench applies that model to every immediate count, every register count up to 2047, every select code and a set of random operands.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 6;
    localparam int CNT_W  = 11;
    localparam int KEEP_W = 4;

    typedef enum logic [1:0] {
        SRC_ONE  = 2'b00,
        SRC_IMM  = 2'b01,
        SRC_REG  = 2'b10,
        SRC_NONE = 2'b11
    } cnt_src_e;

    typedef struct packed {
        logic [KEEP_W-1:0] keep;
        logic              neg;
        logic              zero;
        logic              ovf;
        logic              carry;
    } cc_t;
endpackage

// File: rtl/lsl_count_sel.sv
module lsl_count_sel
    import lsl_pkg::*;
#(
    parameter int IW = IMM_W,
    parameter int CW = CNT_W
) (
    input  logic [1:0]    src_i,
    input  logic [IW-1:0] imm_i,
    input  logic [CW-1:0] reg_i,
    output logic [CW-1:0] cnt_o
);
    cnt_src_e src;
    assign src = cnt_src_e'(src_i);

    always_comb begin
        unique case (src)
            SRC_ONE: cnt_o = CW'(1);
            SRC_IMM: cnt_o = CW'(imm_i);
            SRC_REG: cnt_o = reg_i;
            default: cnt_o = '0;
        endcase
    end
endmodule

// File: rtl/lsl_barrel.sv
module lsl_barrel #(
    parameter int DW  = 32,
    parameter int STG = 6
) (
    input  logic [DW-1:0]  din,
    input  logic [STG-1:0] amt,
    input  logic           oversize,
    output logic [DW-1:0]  dout,
    output logic           carry
);
    // One extra top bit catches the last bit that leaves the word.
    logic [DW:0] stg [STG+1];

    assign stg[0] = {1'b0, din};

    for (genvar k = 0; k < STG; k++) begin : g_stage
        assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
    end

    assign dout  = oversize ? '0   : stg[STG][DW-1:0];
    assign carry = oversize ? 1'b0 : stg[STG][DW];
endmodule

// File: rtl/lsl_flag_gen.sv
module lsl_flag_gen
    import lsl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0]     res_i,
    input  logic              carry_i,
    input  logic [KEEP_W-1:0] keep_i,
    output cc_t               cc_o
);
    always_comb begin
        cc_o.carry = carry_i;
        cc_o.ovf   = 1'b0;
        cc_o.zero  = (res_i == '0);
        cc_o.neg   = res_i[DW-1];
        cc_o.keep  = keep_i;
    end
endmodule

// File: rtl/lsl_flag_unit.sv
module lsl_flag_unit
    import lsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [1:0]        cnt_src_i,
    input  logic [IMM_W-1:0]  imm_cnt_i,
    input  logic [CNT_W-1:0]  cnt_reg_i,
    input  logic [KEEP_W-1:0] cc_keep_i,
    output logic [DATA_W-1:0] res_o,
    output logic [7:0]        cc_out
);
    localparam int STG = $clog2(DATA_W) + 1;

    logic [CNT_W-1:0]  cnt;
    logic              oversize;
    logic [DATA_W-1:0] shifted;
    logic              carry;
    cc_t               cc_next;

    lsl_count_sel #(.IW(IMM_W), .CW(CNT_W)) u_sel (
        .src_i (cnt_src_i),
        .imm_i (imm_cnt_i),
        .reg_i (cnt_reg_i),
        .cnt_o (cnt)
    );

    // Counts of 2**STG and above leave nothing behind.
    assign oversize = |cnt[CNT_W-1:STG];

    lsl_barrel #(.DW(DATA_W), .STG(STG)) u_shift (
        .din      (opnd_i),
        .amt      (cnt[STG-1:0]),
        .oversize (oversize),
        .dout     (shifted),
        .carry    (carry)
    );

    lsl_flag_gen #(.DW(DATA_W)) u_flags (
        .res_i   (shifted),
        .carry_i (carry),
        .keep_i  (cc_keep_i),
        .cc_o    (cc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o  <= '0;
            cc_out <= '0;
        end else begin
            res_o  <= shifted;
            cc_out <= cc_next;
        end
    end
endmodule

// File: rtl/lsl_flag_unit_chk.sv
module lsl_flag_unit_chk
    import lsl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opnd_i,
    input logic [1:0]        cnt_src_i,
    input logic [IMM_W-1:0]  imm_cnt_i,
    input logic [CNT_W-1:0]  cnt_reg_i,
    input logic [KEEP_W-1:0] cc_keep_i,
    input logic [DATA_W-1:0] res_o,
    input logic [7:0]        cc_out
);
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !cc_out[1]);

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cc_out[2] == (res_o == '0)));

    assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cc_out[3] == res_o[DATA_W-1]));

    assert_keep_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cc_out[7:4] == $past(cc_keep_i)));

    assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_src_i == 2'b11 || (cnt_src_i == 2'b01 && imm_cnt_i == '0))
        |=> (res_o == $past(opnd_i) && !cc_out[0]));

    assert_single_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_src_i == 2'b00)
        |=> (res_o == {$past(opnd_i[DATA_W-2:0]), 1'b0}
             && cc_out[0] == $past(opnd_i[DATA_W-1])));

    assert_big_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_src_i == 2'b10 && cnt_reg_i > CNT_W'(DATA_W))
        |=> (res_o == '0 && !cc_out[0]));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |-> (res_o == '0 && cc_out == '0));
endmodule

bind lsl_flag_unit lsl_flag_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_i    (opnd_i),
    .cnt_src_i (cnt_src_i),
    .imm_cnt_i (imm_cnt_i),
    .cnt_reg_i (cnt_reg_i),
    .cc_keep_i (cc_keep_i),
    .res_o     (res_o),
    .cc_out    (cc_out)
);

// File: tb/tb_lsl_flag_unit.sv
module tb_lsl_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] opnd_i;
    logic [1:0]  cnt_src_i;
    logic [5:0]  imm_cnt_i;
    logic [10:0] cnt_reg_i;
    logic [3:0]  cc_keep_i;
    logic [31:0] res_o;
    logic [7:0]  cc_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lsl_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .cnt_src_i(cnt_src_i),
        .imm_cnt_i(imm_cnt_i), .cnt_reg_i(cnt_reg_i), .cc_keep_i(cc_keep_i),
        .res_o(res_o), .cc_out(cc_out)
    );

    // Reference model written from the requirements, using a wide integer.
    function automatic logic [39:0] model(input logic [31:0] x, input logic [1:0] src,
                                          input logic [5:0] imm, input logic [10:0] rc,
                                          input logic [3:0] keep);
        int unsigned n;
        logic [63:0] w;
        logic [31:0] r;
        logic c;
        case (src)
            2'b00:   n = 1;
            2'b01:   n = imm;
            2'b10:   n = rc;
            default: n = 0;
        endcase
        if (n == 0) begin
            r = x; c = 1'b0;
        end else if (n > 32) begin
            r = '0; c = 1'b0;
        end else begin
            w = {32'h0, x} << n;
            r = w[31:0]; c = w[32];
        end
        return {keep, r[31], (r == 0), 1'b0, c, r};
    endfunction

    task automatic compare(input string req, input logic [39:0] exp);
        n_vec++;
        if ({cc_out, res_o} !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h cc=%b, expected res=%h cc=%b",
                     req, res_o, cc_out, exp[31:0], exp[39:32]);
        end
    endtask

    // Drive on a falling edge; the result is due after the next rising edge.
    task automatic apply(input string req, input logic [31:0] x, input logic [1:0] src,
                         input logic [5:0] imm, input logic [10:0] rc, input logic [3:0] keep);
        opnd_i = x; cnt_src_i = src; imm_cnt_i = imm; cnt_reg_i = rc; cc_keep_i = keep;
        @(negedge clk);
        compare(req, model(x, src, imm, rc, keep));
    endtask

    task automatic test_reset();
        compare("R10 reset", 40'h0);
    endtask

    task automatic test_single();
        apply("R1 R2 R3 single", 32'h8000_0001, 2'b00, 6'd17, 11'd99, 4'h5);
        apply("R2 R3 R8 single", 32'h4000_0000, 2'b00, 6'd0, 11'd0, 4'hA);
        apply("R3 R7 single", 32'h8000_0000, 2'b00, 6'd0, 11'd0, 4'h0);
    endtask

    task automatic test_imm_sweep();
        logic [31:0] pats [4] = '{32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0000_0001, 32'h8000_0000};
        foreach (pats[p]) begin
            for (int n = 0; n < 64; n++)
                apply("R1 R2 R3 R4 R5 imm sweep", pats[p], 2'b01, 6'(n), 11'h7FF, 4'(n));
        end
    endtask

    task automatic test_reg_sweep();
        for (int n = 0; n < 2048; n++)
            apply("R1 R5 reg sweep", 32'hDEAD_BEEF ^ 32'(n * 97), 2'b10, 6'd3, 11'(n), 4'(n >> 2));
        apply("R3 count 32", 32'h0000_0001, 2'b10, 6'd0, 11'd32, 4'h1);
        apply("R5 count 33", 32'hFFFF_FFFF, 2'b10, 6'd0, 11'd33, 4'h2);
    endtask

    task automatic test_reserved();
        apply("R1 R4 reserved", 32'h1234_5678, 2'b11, 6'd5, 11'd7, 4'h3);
        apply("R4 R8 reserved", 32'hF000_0000, 2'b11, 6'd63, 11'd2047, 4'hC);
    endtask

    task automatic test_flags();
        apply("R6 R7 zero result", 32'h0000_0000, 2'b01, 6'd4, 11'd0, 4'hF);
        apply("R9 keep bits", 32'h0000_0003, 2'b01, 6'd1, 11'd0, 4'h9);
        apply("R9 keep bits", 32'h0000_0003, 2'b10, 6'd1, 11'd40, 4'h6);
    endtask

    task automatic test_latency();
        logic [39:0] prev;
        apply("R10 latency setup", 32'h0000_00FF, 2'b01, 6'd8, 11'd0, 4'h1);
        prev = model(32'h0000_00FF, 2'b01, 6'd8, 11'd0, 4'h1);
        opnd_i = 32'h0F0F_0000; cnt_src_i = 2'b01; imm_cnt_i = 6'd4; cc_keep_i = 4'hE;
        #1;
        compare("R10 hold before edge", prev);
        @(negedge clk);
        compare("R10 after edge", model(32'h0F0F_0000, 2'b01, 6'd4, 11'd0, 4'hE));
    endtask

    task automatic test_random();
        for (int i = 0; i < 600; i++)
            apply("R2 R3 R7 R8 random", $urandom, 2'($urandom), 6'($urandom),
                  11'($urandom), 4'($urandom));
    endtask

    initial begin
        rst_n = 1'b0;
        opnd_i = '0; cnt_src_i = '0; imm_cnt_i = '0; cnt_reg_i = '0; cc_keep_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_single();
        test_imm_sweep();
        test_reg_sweep();
        test_reserved();
        test_flags();
        test_latency();
        test_random();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule